// File: doc/BRIEF.md
# Lookup-Programmed Ones Counter

This block counts how many bits are set in an input vector. A small datapath walks the vector one bit at a time under the control of a state machine. The state machine's behaviour is not fixed in gates: it is held in small writable lookup memories, so a different algorithm can be obtained by changing memory contents instead of logic.

The next-state logic is a chain of lookup levels. Each level has a selector memory, which picks the condition bit to test for the state it receives, and a transition memory, which maps that state and the chosen bit to a new code. Codes pass from level to level without a register, so one clock can resolve several tests. The last level loads a 3-bit state register. That register addresses an output memory that produces four control strobes for the datapath. An intermediate code (binary 100) exists only between levels and is never stored in the register.

After reset, a startup sequencer copies a built-in constant table into every memory, one word per clock, with a separate write enable for each memory. Until it finishes, the state machine and the datapath are held cleared. After that, the block scans the vector continuously. It presents a fresh count followed by a one-cycle ready pulse every ten clocks. The vector must stay stable from one ready pulse until the next.

Top module: `popcnt_rfsm_top`

## Requirements
- R1: After reset the sequencer writes 56 table words on 56 consecutive clocks. During that time the state register is held at 000, `ready_o` is 0 and `count_o` is 0.
- R2: State codes are start=000, clear=001, step=010, step-and-count=011. The intermediate code 100 is never held in the state register, and neither is any code above 011.
- R3: In each level, the selector memory is addressed by the incoming code and picks the condition bit: index 0 is the end flag and index 1 is the current vector bit. The transition memory is addressed by {incoming code, selected bit} and gives the outgoing code. Level 1 sends start to clear. From any other state, level 1 sends end=1 to start and end=0 to 100. Level 2 sends 100 with bit=1 to step-and-count and 100 with bit=0 to step, and passes every other code through unchanged.
- R4: Each output word holds copy in bit 0, clear in bit 1, step in bit 2 and count in bit 3. The words are start=0001, clear=0010, step=0100, step-and-count=1100, and 0000 for every other code.
- R5: The datapath updates on the falling clock edge. Copy moves the ones count to `count_o`. Clear zeroes both the bit index and the ones count. Step adds one to the index. Count adds one to the ones count.
- R6: After each datapath update, the end flag is 1 when the new index is 8 or more. Otherwise the end flag is 0 and the bit flag takes `vec_i` at the new index.
- R7: Each reported `count_o` equals the number of set bits in the vector held during the scan that precedes it.
- R8: `ready_o` is high for exactly one cycle. It rises on the clock after a copy strobe, but not for the first copy after loading, which reports no scan. `count_o` changes only just before a ready pulse.
- R9: Successive ready pulses are exactly 10 clocks apart.
- R10: The first ready pulse comes on the 67th rising edge after reset is released.
- R11: A vector of all zeros reports 0 and a vector of all ones reports 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the control logic uses the rising edge and the datapath the falling edge |
| rst | input | 1 | Synchronous active-high reset; restarts the table load |
| vec_i | input | VEC_W | Vector whose set bits are counted |
| count_o | output | $clog2(VEC_W+1) | Last reported ones count |
| ready_o | output | 1 | One-cycle pulse when a new count is on `count_o` |

## Verification
The assertions check on every cycle that the state register stays at 000 while loading, that it never holds a code of 100 or above, that ready is a single-cycle pulse absent during loading, and that any change of the count is followed by ready. The table contents, the traversal order of the levels and the strobe effects can only be shown end to end by the bench. It checks the reported counts against the bit count of each applied vector, including the all-zero and all-one boundaries, and checks the exact latency of the first result and the ten-clock spacing after it.

// File: rtl/rfsm_pkg.sv
package rfsm_pkg;
  // state codes
  localparam int ST_START = 0;
  localparam int ST_CLEAR = 1;
  localparam int ST_STEP  = 2;
  localparam int ST_COUNT = 3;
  localparam int ST_MID   = 4;  // only between levels

  // condition vector indices
  localparam int C_END = 0;
  localparam int C_BIT = 1;
  localparam int NCOND = 2;

  // strobe bit positions
  localparam int Y_COPY = 0;
  localparam int Y_CLR  = 1;
  localparam int Y_STEP = 2;
  localparam int Y_ONE  = 3;
  localparam int Y_W    = 4;

  // selector entry: which condition a level tests for a code (R3)
  function automatic int sel_code(int lvl, int st);
    if (lvl == 0) return C_END;
    return (st == ST_MID) ? C_BIT : C_END;
  endfunction

  // transition entry (R3)
  function automatic int nxt_code(int lvl, int nlvl, int st, int c);
    if (lvl == 0) begin
      if (st == ST_START) return ST_CLEAR;
      if (st >= ST_CLEAR && st <= ST_COUNT) return (c != 0) ? ST_START : ST_MID;
      return ST_START;
    end
    if (lvl == nlvl - 1) begin
      if (st == ST_MID) return (c != 0) ? ST_COUNT : ST_STEP;
      if (st <= ST_COUNT) return st;
      return ST_START;
    end
    if (st <= ST_MID) return st;
    return ST_START;
  endfunction

  // output entry (R4)
  function automatic int out_code(int st);
    case (st)
      ST_START: return 1 << Y_COPY;
      ST_CLEAR: return 1 << Y_CLR;
      ST_STEP:  return 1 << Y_STEP;
      ST_COUNT: return (1 << Y_STEP) | (1 << Y_ONE);
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/rfsm_lut_ram.sv
module rfsm_lut_ram #(
  parameter int AW = 3,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read: distributed RAM
  assign rdata = mem[raddr];
endmodule

// File: rtl/rfsm_level.sv
module rfsm_level #(
  parameter int ST_W  = 3,
  parameter int NCOND = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             sel_we,
  input  logic             tr_we,
  input  logic [ST_W:0]    waddr,
  input  logic [ST_W-1:0]  wdata,
  input  logic [NCOND-1:0] cond_i,
  input  logic [ST_W-1:0]  st_i,
  output logic [ST_W-1:0]  st_o
);
  logic [SEL_W-1:0] pick;
  logic             bit_sel;

  rfsm_lut_ram #(.AW(ST_W), .DW(SEL_W)) u_sel (
    .clk   (clk),
    .we    (sel_we),
    .waddr (waddr[ST_W-1:0]),
    .wdata (wdata[SEL_W-1:0]),
    .raddr (st_i),
    .rdata (pick)
  );

  assign bit_sel = cond_i[pick];

  rfsm_lut_ram #(.AW(ST_W + 1), .DW(ST_W)) u_tr (
    .clk   (clk),
    .we    (tr_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr ({st_i, bit_sel}),
    .rdata (st_o)
  );
endmodule

// File: rtl/rfsm_loader.sv
module rfsm_loader
  import rfsm_pkg::*;
#(
  parameter int NLVL  = 2,
  parameter int ST_W  = 3,
  parameter int DAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy_o,
  output logic [NLVL-1:0]  sel_we_o,
  output logic [NLVL-1:0]  tr_we_o,
  output logic             out_we_o,
  output logic [ST_W:0]    waddr_o,
  output logic [DAT_W-1:0] wdata_o
);
  localparam int ST_D  = 1 << ST_W;
  localparam int TR_D  = 1 << (ST_W + 1);
  localparam int WPL   = ST_D + TR_D;
  localparam int OFF_W = $clog2(WPL);
  localparam int LV_W  = $clog2(NLVL + 1);

  logic [LV_W-1:0]  lvl_q;
  logic [OFF_W-1:0] off_q;
  logic             done_q;
  logic             in_out, in_tr;
  logic [OFF_W-1:0] toff;
  int               d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      off_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (lvl_q == LV_W'(NLVL)) begin
        if (off_q == OFF_W'(ST_D - 1)) done_q <= 1'b1;
        else                           off_q  <= off_q + 1'b1;
      end else if (off_q == OFF_W'(WPL - 1)) begin
        off_q <= '0;
        lvl_q <= lvl_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign busy_o = !done_q;
  assign in_out = (lvl_q == LV_W'(NLVL));
  assign in_tr  = !in_out && (off_q >= OFF_W'(ST_D));
  assign toff   = off_q - OFF_W'(ST_D);

  always_comb begin
    if (in_out)     d = out_code(int'(off_q));
    else if (in_tr) d = nxt_code(int'(lvl_q), NLVL, int'(toff) >> 1, int'(toff) & 1);
    else            d = sel_code(int'(lvl_q), int'(off_q));
    wdata_o = DAT_W'(d);
    waddr_o = in_tr ? toff[ST_W:0] : {1'b0, off_q[ST_W-1:0]};
    out_we_o = !done_q && in_out;
    for (int g = 0; g < NLVL; g++) begin
      sel_we_o[g] = !done_q && !in_out && !in_tr && (lvl_q == LV_W'(g));
      tr_we_o[g]  = !done_q && in_tr && (lvl_q == LV_W'(g));
    end
  end
endmodule

// File: rtl/ones_datapath.sv
module ones_datapath
  import rfsm_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [Y_W-1:0]   y_i,
  output logic             x_end_o,
  output logic             x_bit_o,
  output logic [CNT_W-1:0] result_o
);
  localparam int LOG = $clog2(VEC_W);

  logic [CNT_W-1:0] idx_q, ones_q, idx_n, ones_n;

  // strobe effects in order: clear, then increments (R5)
  always_comb begin
    idx_n  = y_i[Y_CLR] ? '0 : idx_q;
    ones_n = y_i[Y_CLR] ? '0 : ones_q;
    idx_n  = idx_n + CNT_W'(y_i[Y_STEP]);
    ones_n = ones_n + CNT_W'(y_i[Y_ONE]);
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      ones_q   <= '0;
      result_o <= '0;
      x_end_o  <= 1'b0;
      x_bit_o  <= 1'b0;
    end else begin
      if (y_i[Y_COPY]) result_o <= ones_q;
      idx_q  <= idx_n;
      ones_q <= ones_n;
      // condition flags from the updated index (R6)
      if (idx_n >= CNT_W'(VEC_W)) begin
        x_end_o <= 1'b1;
      end else begin
        x_end_o <= 1'b0;
        x_bit_o <= vec_i[idx_n[LOG-1:0]];
      end
    end
  end
endmodule

// File: rtl/popcnt_rfsm_top.sv
module popcnt_rfsm_top
  import rfsm_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int ST_W  = 3,
  parameter int NLVL  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [VEC_W-1:0]           vec_i,
  output logic [$clog2(VEC_W+1)-1:0] count_o,
  output logic                       ready_o
);
  localparam int CNT_W = $clog2(VEC_W + 1);
  localparam int SEL_W = $clog2(NCOND);
  localparam int DAT_W = (ST_W > Y_W) ? ST_W : Y_W;

  logic             load_busy, hold;
  logic [NLVL-1:0]  sel_we, tr_we;
  logic             out_we;
  logic [ST_W:0]    waddr;
  logic [DAT_W-1:0] wdata;
  logic [ST_W-1:0]  lvl_st [NLVL+1];
  logic [ST_W-1:0]  state_q;
  logic [Y_W-1:0]   ystb;
  logic             x_end, x_bit;
  logic [NCOND-1:0] cond;
  logic             primed_q;

  assign hold = rst | load_busy;

  rfsm_loader #(.NLVL(NLVL), .ST_W(ST_W), .DAT_W(DAT_W)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .busy_o   (load_busy),
    .sel_we_o (sel_we),
    .tr_we_o  (tr_we),
    .out_we_o (out_we),
    .waddr_o  (waddr),
    .wdata_o  (wdata)
  );

  always_comb begin
    cond        = '0;
    cond[C_END] = x_end;
    cond[C_BIT] = x_bit;
  end

  assign lvl_st[0] = state_q;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    rfsm_level #(.ST_W(ST_W), .NCOND(NCOND), .SEL_W(SEL_W)) u_level (
      .clk    (clk),
      .sel_we (sel_we[g]),
      .tr_we  (tr_we[g]),
      .waddr  (waddr),
      .wdata  (wdata[ST_W-1:0]),
      .cond_i (cond),
      .st_i   (lvl_st[g]),
      .st_o   (lvl_st[g+1])
    );
  end

  // state register loads from the last level (R2)
  always_ff @(posedge clk) begin
    if (hold) state_q <= ST_W'(ST_START);
    else      state_q <= lvl_st[NLVL];
  end

  rfsm_lut_ram #(.AW(ST_W), .DW(Y_W)) u_outram (
    .clk   (clk),
    .we    (out_we),
    .waddr (waddr[ST_W-1:0]),
    .wdata (wdata[Y_W-1:0]),
    .raddr (state_q),
    .rdata (ystb)
  );

  ones_datapath #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (hold),
    .vec_i    (vec_i),
    .y_i      (ystb),
    .x_end_o  (x_end),
    .x_bit_o  (x_bit),
    .result_o (count_o)
  );

  // ready pulse after a copy that follows a real scan (R8)
  always_ff @(posedge clk) begin
    if (hold) begin
      primed_q <= 1'b0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= ystb[Y_COPY] & primed_q;
      if (ystb[Y_CLR]) primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rfsm_checker.sv
module rfsm_checker #(
  parameter int ST_W  = 3,
  parameter int VEC_W = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       busy,
  input logic [ST_W-1:0]            state_q,
  input logic                       ready_o,
  input logic [$clog2(VEC_W+1)-1:0] count_o
);
  a_r1_hold_in_load: assert property (@(posedge clk) disable iff (rst)
    busy |=> (state_q == '0));

  a_r1_no_ready_load: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready_o);

  a_r2_state_legal: assert property (@(posedge clk) disable iff (rst)
    state_q < ST_W'(4));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  a_r8_change_then_ready: assert property (@(posedge clk) disable iff (rst)
    !$stable(count_o) |=> ready_o);

  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    count_o <= ($clog2(VEC_W+1))'(VEC_W));
endmodule

bind popcnt_rfsm_top rfsm_checker #(.ST_W(ST_W), .VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (load_busy),
  .state_q (state_q),
  .ready_o (ready_o),
  .count_o (count_o)
);

// File: tb/popcnt_rfsm_top_bench.sv
module popcnt_rfsm_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] vec = 8'h00;
  logic [3:0] count;
  logic       ready;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  logic [7:0] vlist[$];

  always #5 clk = ~clk;

  popcnt_rfsm_top u_popcnt_rfsm_top (
    .clk(clk), .rst(rst), .vec_i(vec), .count_o(count), .ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply a vector and queue its expected count
  task automatic drive_vec(input logic [7:0] v);
    vec = v;
    exp_q.push_back($countones(v));
  endtask

  // monitor: pop the expectation and compare (R7, R11 at the boundaries)
  task automatic take_result();
    int e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R7 unexpected result", int'(count), -1);
    end else begin
      e = exp_q.pop_front();
      check(int'(count) == e, (e == 0 || e == 8) ? "R11 boundary count" : "R7 count", int'(count), e);
    end
  endtask

  initial begin
    int cyc = 0;
    int last = 0;
    int nres = 0;
    int held = 0;
    bit done = 0;
    vlist = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hAA, 8'h55, 8'h0F, 8'hF0};
    for (int i = 0; i < 20; i++) vlist.push_back(8'($urandom()));

    repeat (3) @(posedge clk);
    #1;
    check(count == 4'd0, "R1 reset count", int'(count), 0);
    check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    drive_vec(vlist.pop_front());
    rst = 1'b0;

    while (!done && cyc < 3000) begin
      @(posedge clk);
      #1;
      cyc++;
      if (cyc <= 56) begin
        // loading phase: machine held (R1)
        check(ready == 1'b0 && count == 4'd0, "R1 held while loading", int'(ready), 0);
      end else if (ready) begin
        if (nres == 0) check(cyc == 67, "R10 first result latency", cyc, 67);
        else           check(cyc - last == 10, "R9 result spacing", cyc - last, 10);
        last = cyc;
        nres++;
        held = int'(count);
        take_result();
        if (vlist.size() > 0) drive_vec(vlist.pop_front());
        else                  done = 1;
      end else if (nres > 0 && (cyc - last) == 1) begin
        check(ready == 1'b0, "R8 ready one cycle", int'(ready), 0);
      end else if (nres > 0 && (cyc - last) == 5) begin
        check(int'(count) == held, "R8 count stable between results", int'(count), held);
      end
    end

    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=<3000", cyc);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule